// File: doc/BRIEF.md
# Flight-Phase Valve Command Selector

This block picks a two-bit valve and throttle command from a coded flight phase and a launch countdown. It is a single registered stage. Each clock edge samples the phase code and the countdown, and the chosen command appears on the output one cycle later. On the ground the valves stay closed until the countdown reaches the configured start mark, and at that point the start sequence is commanded. The low altitude band asks for throttle-down and the high altitude band asks for throttle-up.

The phase code is three bits wide, so five of its eight values have no meaning. A code like that can arrive after a bit flip on the input wires. Every branch of the decode is written out, so an unknown code never produces a new command: the registered command is kept. A one-cycle fault pulse marks the first cycle of each such episode.

Top module: `valve_phase_selector`

## Requirements
- R1: While `rst` is high, at each clock edge `valve_cmd` becomes CLOSED (00) and `phase_fault` becomes 0.
- R2: If the edge samples phase 000 (ground) with `countdown` equal to START_MARK (default 4), `valve_cmd` becomes OPEN_SEQ (01) after that edge.
- R3: If the edge samples phase 000 with `countdown` at any other value, `valve_cmd` becomes CLOSED (00).
- R4: If the edge samples phase 001 (low band), `valve_cmd` becomes THROTTLE_DN (10), whatever the countdown.
- R5: If the edge samples phase 010 (high band), `valve_cmd` becomes THROTTLE_UP (11), whatever the countdown.
- R6: If the edge samples any of the codes 011 to 111, `valve_cmd` keeps its value, whatever the countdown.
- R7: `phase_fault` is 1 for exactly the cycle that follows the first edge sampling an undefined code after a defined code or after reset. While undefined codes continue it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| phase_code | input | 3 | Flight phase: 000 ground, 001 low band, 010 high band, others undefined |
| countdown | input | CNT_W | Countdown value in seconds |
| valve_cmd | output | 2 | Registered command: 00 closed, 01 start sequence, 10 throttle-down, 11 throttle-up |
| phase_fault | output | 1 | One-cycle pulse on entry into an undefined phase code |

## Verification
Both outputs are due one cycle after the edge that samples the inputs, because each passes through exactly one register. The bench changes inputs just after a rising edge, waits for the next rising edge, and samples 1 ns later. Each check therefore sees the result of exactly one sampled input set. The hold and fault cases run over several consecutive cycles, so the checks catch a command that drifts later and a fault pulse that lasts longer than one cycle.

// File: rtl/valve_sel_pkg.sv
package valve_sel_pkg;

    localparam int PHASE_W = 3;
    localparam int CMD_W   = 2;

    localparam logic [PHASE_W-1:0] PHASE_GROUND = 3'b000;
    localparam logic [PHASE_W-1:0] PHASE_LOW    = 3'b001;
    localparam logic [PHASE_W-1:0] PHASE_HIGH   = 3'b010;

    typedef enum logic [CMD_W-1:0] {
        CMD_CLOSED = 2'b00,
        CMD_START  = 2'b01,
        CMD_THR_DN = 2'b10,
        CMD_THR_UP = 2'b11
    } cmd_e;

    typedef enum logic [1:0] {
        CLS_GROUND,
        CLS_LOW,
        CLS_HIGH,
        CLS_UNKNOWN
    } phase_class_e;

    typedef struct packed {
        phase_class_e cls;
        logic         unknown;
    } phase_info_t;

    function automatic phase_info_t classify(input logic [PHASE_W-1:0] code);
        phase_info_t info;
        case (code)
            PHASE_GROUND: info = '{cls: CLS_GROUND,  unknown: 1'b0};
            PHASE_LOW:    info = '{cls: CLS_LOW,     unknown: 1'b0};
            PHASE_HIGH:   info = '{cls: CLS_HIGH,    unknown: 1'b0};
            default:      info = '{cls: CLS_UNKNOWN, unknown: 1'b1};
        endcase
        return info;
    endfunction

endpackage

// File: rtl/phase_decode.sv
module phase_decode
    import valve_sel_pkg::*;
(
    input  logic [PHASE_W-1:0] phase_code,
    output phase_info_t        info
);
    always_comb begin
        info = classify(phase_code);
    end
endmodule

// File: rtl/cmd_select.sv
module cmd_select
    import valve_sel_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int START_MARK = 4
) (
    input  phase_info_t      info,
    input  logic [CNT_W-1:0] countdown,
    input  cmd_e             cur_cmd,
    output cmd_e             nxt_cmd
);
    localparam logic [CNT_W-1:0] MARK = CNT_W'(START_MARK);

    always_comb begin
        case (info.cls)
            CLS_GROUND: begin
                if (countdown == MARK) nxt_cmd = CMD_START;
                else                   nxt_cmd = CMD_CLOSED;
            end
            CLS_LOW:  nxt_cmd = CMD_THR_DN;
            CLS_HIGH: nxt_cmd = CMD_THR_UP;
            default:  nxt_cmd = cur_cmd;
        endcase
    end
endmodule

// File: rtl/cmd_reg.sv
module cmd_reg
    import valve_sel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  cmd_e nxt_cmd,
    input  logic unknown,
    output cmd_e cmd_q,
    output logic fault_q
);
    logic in_fault_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q      <= CMD_CLOSED;
            fault_q    <= 1'b0;
            in_fault_q <= 1'b0;
        end else begin
            cmd_q      <= nxt_cmd;
            fault_q    <= unknown & ~in_fault_q;
            in_fault_q <= unknown;
        end
    end
endmodule

// File: rtl/valve_phase_selector.sv
module valve_phase_selector
    import valve_sel_pkg::*;
#(
    parameter int CNT_W      = 8,
    parameter int START_MARK = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [2:0]          phase_code,
    input  logic [CNT_W-1:0]    countdown,
    output logic [1:0]          valve_cmd,
    output logic                phase_fault
);
    phase_info_t info;
    cmd_e        cmd_q;
    cmd_e        nxt_cmd;
    logic        fault_q;

    phase_decode u_decode (
        .phase_code (phase_code),
        .info       (info)
    );

    cmd_select #(
        .CNT_W      (CNT_W),
        .START_MARK (START_MARK)
    ) u_select (
        .info      (info),
        .countdown (countdown),
        .cur_cmd   (cmd_q),
        .nxt_cmd   (nxt_cmd)
    );

    cmd_reg u_reg (
        .clk     (clk),
        .rst     (rst),
        .nxt_cmd (nxt_cmd),
        .unknown (info.unknown),
        .cmd_q   (cmd_q),
        .fault_q (fault_q)
    );

    assign valve_cmd   = cmd_q;
    assign phase_fault = fault_q;
endmodule

// File: rtl/valve_phase_selector_chk.sv
module valve_phase_selector_chk #(
    parameter int CNT_W      = 8,
    parameter int START_MARK = 4
) (
    input logic             clk,
    input logic             rst,
    input logic [2:0]       phase_code,
    input logic [CNT_W-1:0] countdown,
    input logic [1:0]       valve_cmd,
    input logic             phase_fault
);
    localparam logic [CNT_W-1:0] MARK = CNT_W'(START_MARK);

    logic undefined;
    always_comb undefined = (phase_code > 3'b010);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (valve_cmd == 2'b00) && !phase_fault); // R1

    AST_GROUND_START: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'b000 && countdown == MARK) |=> valve_cmd == 2'b01); // R2

    AST_GROUND_IDLE: assert property (@(posedge clk) disable iff (rst)
        (phase_code == 3'b000 && countdown != MARK) |=> valve_cmd == 2'b00); // R3

    AST_LOW_BAND: assert property (@(posedge clk) disable iff (rst)
        phase_code == 3'b001 |=> valve_cmd == 2'b10); // R4

    AST_HIGH_BAND: assert property (@(posedge clk) disable iff (rst)
        phase_code == 3'b010 |=> valve_cmd == 2'b11); // R5

    AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (rst)
        undefined |=> $stable(valve_cmd)); // R6

    AST_FAULT_SINGLE: assert property (@(posedge clk) disable iff (rst)
        phase_fault |=> !phase_fault); // R7

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        (undefined && !phase_fault) |=> (phase_fault || $past(phase_fault) || $past(undefined, 2) || $past(rst, 1))); // R7
endmodule

bind valve_phase_selector valve_phase_selector_chk #(
    .CNT_W      (CNT_W),
    .START_MARK (START_MARK)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .phase_code  (phase_code),
    .countdown   (countdown),
    .valve_cmd   (valve_cmd),
    .phase_fault (phase_fault)
);

// File: tb/test_valve_phase_selector.sv
`timescale 1ns/1ps
module test_valve_phase_selector;
    localparam int CNT_W = 8;
    localparam int MARK  = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [2:0]       phase_code = 3'b000;
    logic [CNT_W-1:0] countdown = '0;
    logic [1:0]       valve_cmd;
    logic             phase_fault;

    int n_checks = 0;
    int n_bad    = 0;
    logic [1:0] exp_cmd = 2'b00;
    logic       was_undef = 1'b0;

    always #5 clk = ~clk;

    valve_phase_selector #(.CNT_W(CNT_W), .START_MARK(MARK)) i_valve_phase_selector (
        .clk         (clk),
        .rst         (rst),
        .phase_code  (phase_code),
        .countdown   (countdown),
        .valve_cmd   (valve_cmd),
        .phase_fault (phase_fault)
    );

    task automatic check(input string req, input int actual, input int expected);
        n_checks++;
        if (actual != expected) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // apply one input set, wait one edge, check both outputs against the model
    task automatic step(input string req, input logic [2:0] ph, input int cnt);
        logic exp_fault;
        phase_code = ph;
        countdown  = CNT_W'(cnt);
        exp_fault  = 1'b0;
        case (ph)
            3'b000: exp_cmd = (cnt == MARK) ? 2'b01 : 2'b00;
            3'b001: exp_cmd = 2'b10;
            3'b010: exp_cmd = 2'b11;
            default: begin
                exp_fault = !was_undef;
            end
        endcase
        was_undef = (ph > 3'b010);
        @(posedge clk); #1;
        check({req, " cmd"}, int'(valve_cmd), int'(exp_cmd));
        check({req, " fault"}, int'(phase_fault), int'(exp_fault));
    endtask

    task automatic t_reset();
        rst = 1'b1;
        phase_code = 3'b001;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R1 cmd", int'(valve_cmd), 0);
        check("R1 fault", int'(phase_fault), 0);
        rst = 1'b0;
        exp_cmd = 2'b00;
        was_undef = 1'b0;
    endtask

    task automatic t_ground();
        step("R3", 3'b000, 10);
        step("R3", 3'b000, 5);
        step("R2", 3'b000, MARK);
        step("R3", 3'b000, 3);
        step("R2", 3'b000, MARK);
        step("R3", 3'b000, 0);
    endtask

    task automatic t_bands();
        step("R4", 3'b001, MARK);
        step("R4", 3'b001, 200);
        step("R5", 3'b010, 0);
        step("R5", 3'b010, MARK);
        step("R4", 3'b001, 1);
    endtask

    task automatic t_hold();
        for (int c = 3; c < 8; c++) step("R6", 3'(c), MARK);
        step("R5", 3'b010, 9);
        step("R6", 3'b111, 0);
        step("R6", 3'b011, MARK);
        step("R2", 3'b000, MARK);
        step("R6", 3'b100, 2);
        step("R3", 3'b000, 7);
        step("R6", 3'b101, MARK);
    endtask

    task automatic t_fault();
        step("R7", 3'b001, 0);
        step("R7", 3'b110, 0);
        step("R7", 3'b110, 0);
        step("R7", 3'b011, 0);
        step("R7", 3'b010, 0);
        step("R7", 3'b111, 0);
        step("R7", 3'b000, 0);
        step("R7", 3'b100, 0);
        // undefined code straight after reset
        rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        exp_cmd = 2'b00;
        was_undef = 1'b0;
        step("R7", 3'b101, 0);
        step("R7", 3'b101, 0);
    endtask

    initial begin
        #200000;
        n_checks++;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_ground();
        t_bands();
        t_hold();
        t_fault();
        $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end
endmodule